// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned word by another and produces one quotient bit per clock. A single double-width shift register carries both values. The partial remainder sits in its upper part, and quotient bits fill the lower part as dividend bits leave it. A trial subtractor compares the partial remainder against the divisor on every step. The difference is kept only when the subtraction does not borrow. When it borrows, the old partial remainder stays in place.

A caller presents the operands and pulses `start` while the divider is idle. The operands are captured on that edge, and `busy` stays high while the iterations run. At the end, `done` pulses once, the quotient appears on `quotient` and the remainder on `remainder`. The outputs hold until the next accepted start. A zero divisor raises no error: the quotient is all ones and the remainder equals the dividend.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` seen on a rising edge while `busy` is low is accepted, and `busy` is high in the cycle after that edge.
- R3: `done` is high for exactly one clock cycle. It rises on the (W+1)-th rising edge after the accepting edge, so it lies W+2 cycles after the cycle in which `start` was presented.
- R4: For a nonzero divisor, the outputs after `done` satisfy dividend = divisor*quotient + remainder with remainder < divisor.
- R5: For a zero divisor, `quotient` is all ones and `remainder` equals the dividend.
- R6: A `start` while `busy` is high is ignored. The running division completes on its normal schedule with its own operands, and no second `done` follows.
- R7: `dividend` and `divisor` are sampled only on the accepting edge. Changes on them while `busy` is high do not alter the result.
- R8: `quotient` and `remainder` hold their values from `done` until the next accepted start.
- R9: `busy` and `done` are never high in the same cycle.
- R10: When the divisor exceeds the dividend, `quotient` is zero and `remainder` equals the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a division; honoured only when idle |
| dividend | input | W | Unsigned numerator |
| divisor | input | W | Unsigned denominator |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | W | Integer quotient (lower half of the working register) |
| remainder | output | W | Remainder (upper half of the working register) |

## Verification
The embedded properties check several rules on every clock:
- the single-cycle width of `done`;
- that `busy` and `done` never overlap;
- acceptance of an idle start, and that a start during a run leaves the run going;
- that the captured divisor cannot move mid-run;
- that the partial remainder stays below twice the divisor before each step, and that the kept difference fits the word.

The arithmetic results, the exact completion latency, the zero-divisor convention, and the holding of results after `done` can only be shown by the scoreboard scenarios. Those scenarios cover fixed corner operands, random operands of varied magnitude, and a run with operands and start toggled mid-division.

// File: rtl/div_pkg.sv
// Shared definitions for the sequential divider.
// Assumes nothing beyond a single clock domain.
package div_pkg;

    // Controller phases: idle, iterating, final remainder correction.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_trial_sub.sv
// Trial subtractor: subtracts a W-bit divisor from a (W+1)-bit partial
// remainder and reports a borrow when the divisor is larger.
// Assumes both operands are unsigned.
module div_trial_sub #(
    parameter int W = 32
) (
    input  logic [W:0]   minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W:0]   diff,
    output logic         borrow
);

    localparam int XW = W + 2;

    logic [XW-1:0] wide;

    // Extended subtraction; the top bit is the borrow out.
    always_comb begin
        wide   = {1'b0, minuend} - {2'b00, subtrahend};
        diff   = wide[W:0];
        borrow = wide[XW-1];
    end

endmodule

// File: rtl/div_ctrl.sv
// Sequencing for the divider: accepts start when idle, runs W iteration
// cycles, one correction cycle, then pulses done for one cycle.
// Assumes W >= 2 and a synchronous active-low reset.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);

    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state;
    logic [CW-1:0] cnt;

    // Decode phase strobes for the datapath.
    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        fix  = (state == ST_FIX);
        busy = (state != ST_IDLE);
    end

    // Phase register, iteration counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt == LAST) begin
                        state <= ST_FIX;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FIX: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: completion is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: never busy and done together.
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2: an idle start is taken up on the next cycle.
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: a start during iteration does not end or restart the run.
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start) |=> busy);

endmodule

// File: rtl/div_datapath.sv
// Working register for the divider. The upper W+1 bits hold the partial
// remainder and the lower W bits receive quotient bits. A restore is done
// by not committing the trial difference.
// Assumes load, step and fix are mutually exclusive single-phase strobes.
module div_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         fix,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    localparam int RW = 2 * W + 1;

    logic [RW-1:0] rq_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    hi;
    logic [W-1:0]  lo;
    logic [W:0]    diff;
    logic          borrow;
    logic [W:0]    hi_next;

    // Split the working register into remainder and quotient parts.
    always_comb begin
        hi = rq_q[RW-1:W];
        lo = rq_q[W-1:0];
    end

    div_trial_sub #(.W(W)) u_sub (
        .minuend    (hi),
        .subtrahend (dvs_q),
        .diff       (diff),
        .borrow     (borrow)
    );

    // Keep the difference only when no borrow occurred.
    always_comb hi_next = borrow ? hi : diff;

    // Load with pre-shift, iterate with shift-in of quotient bit, then correct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q  <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rq_q  <= {{W{1'b0}}, dividend, 1'b0};
            dvs_q <= divisor;
        end else if (step) begin
            rq_q  <= {hi_next[W-1:0], lo, ~borrow};
        end else if (fix) begin
            rq_q  <= {1'b0, hi[W:1], lo};
        end
    end

    // Drive results from the two halves.
    always_comb begin
        quotient  = lo;
        remainder = hi[W-1:0];
    end

    // R7: the captured divisor stays fixed through the iterations.
    p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(dvs_q));

    // R4: before each step the partial remainder is below twice the divisor.
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q != '0) |-> (hi < {dvs_q, 1'b0}));

    // R4: the committed partial remainder fits in W bits.
    p_commit_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !hi_next[W]);

    // R4: the spare bit under the remainder is clear before correction.
    p_spare_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fix |-> !rq_q[W]);

    // R5: a zero divisor never borrows, so every quotient bit is one.
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q == '0) |-> !borrow);

endmodule

// File: rtl/seq_divider.sv
// Top of the sequential unsigned divider: one quotient bit per cycle,
// start/busy/done handshake, quotient and remainder held after done.
// Assumes W >= 2; a zero divisor yields all-ones quotient, dividend remainder.
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    logic load;
    logic step;
    logic fix;

    div_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    div_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .fix       (fix),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

endmodule

// File: tb/seq_divider_tb.sv
`timescale 1ns/1ps
module seq_divider_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    seq_divider #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] q;
        logic [W-1:0] r;
        int           t;
    } item_t;

    item_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each done and checks handshake rules.
    bit prev_done = 1'b0;
    always @(negedge clk) begin : monitor
        item_t e;
        if (rst_n && !finished) begin
            if (busy && done) check(1'b0, "R9", "busy with done", 1, 0);
            if (prev_done) check(!done, "R3", "done width", 64'(done), 0);
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(quotient == e.q, (e.b == '0) ? "R5" : "R4", "quotient", 64'(quotient), 64'(e.q));
                    check(remainder == e.r, (e.b == '0) ? "R5" : "R4", "remainder", 64'(remainder), 64'(e.r));
                    // R3: done seen W+2 cycles after the cycle start was presented.
                    check((cyc - e.t) == W + 2, "R3", "latency", 64'(cyc - e.t), 64'(W + 2));
                end
            end
            prev_done = done;
        end
    end

    // Driver: queue the expected result, present the start, await completion.
    task automatic push_start(input logic [W-1:0] a, input logic [W-1:0] b);
        item_t e;
        e.a = a;
        e.b = b;
        e.q = (b == '0) ? '1 : a / b;
        e.r = (b == '0) ? a : a % b;
        e.t = cyc;
        sb.push_back(e);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R2", "busy after start", 64'(busy), 1);
    endtask

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] q0;
        logic [W-1:0] r0;
        @(negedge clk);
        while (busy) @(negedge clk);
        push_start(a, b);
        while (!done) @(negedge clk);
        q0 = quotient;
        r0 = remainder;
        dividend = ~a;
        divisor  = b ^ 32'h5A5A_0F0F;
        repeat (4) @(negedge clk);
        check(quotient == q0, "R8", "quotient held", 64'(quotient), 64'(q0));
        check(remainder == r0, "R8", "remainder held", 64'(remainder), 64'(r0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1", "busy after reset", 64'(busy), 0);
        check(!done, "R1", "done after reset", 64'(done), 0);
        check(quotient == '0, "R1", "quotient after reset", 64'(quotient), 0);
        check(remainder == '0, "R1", "remainder after reset", 64'(remainder), 0);

        run_div(32'd73, 32'd5);
        run_div(32'd7, 32'd2);
        run_div(32'd1000, 32'd1);
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_div(32'hFFFF_FFFF, 32'h8000_0001);
        run_div(32'd0, 32'd7);
        // R5: zero divisor cases.
        run_div(32'h1234_5678, 32'd0);
        run_div(32'd0, 32'd0);
        // R10: divisor larger than dividend.
        run_div(32'd5, 32'd9);
        check(quotient == '0, "R10", "small dividend quotient", 64'(quotient), 0);
        check(remainder == 32'd5, "R10", "small dividend remainder", 64'(remainder), 5);

        // R6 and R7: start and operand changes during a run are ignored.
        @(negedge clk);
        push_start(32'hDEAD_BEEF, 32'd1234);
        repeat (5) @(negedge clk);
        dividend = 32'd1;
        divisor  = 32'd3;
        start    = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!busy, "R6", "no restart after done", 64'(busy), 0);
        repeat (W + 6) @(negedge clk);
        check(sb.size() == 0, "R7", "scoreboard drained", 64'(sb.size()), 0);

        void'($urandom(7));
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = $urandom;
            b = $urandom >> ($urandom % W);
            run_div(a, b);
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4", "all results seen", 64'(sb.size()), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule